// File: doc/BRIEF.md
# Home Directory Coherence Controller

This block is the home node for a group of memory blocks in a small shared-memory machine with `NPROC` processors. Caches send it read-miss, write-miss and write-back requests on one request channel. Each request carries a processor number and a block address. For every block the controller holds a directory entry and a copy of the block's data. The directory entry is one of three states plus one presence bit per processor.

The controller answers each request with messages addressed to single caches. These are data replies, invalidates, fetches, fetch-and-invalidates and write-back acknowledgements. It never broadcasts. When the memory copy is stale it fetches the block from the owning cache. It then holds every other request until that owner's write back arrives. Invalidates for a write to a shared block leave one per cycle, in ascending processor order, ahead of the data reply. Requests are handled strictly in the order they are accepted.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty sharer set. Block `i` holds the data value `i`. `out_valid` is low and `req_ready` is high.
- R2: A read miss (`req_kind`=0) to an Uncached or Shared block returns a data reply (`out_kind`=0) with the memory value to the requester. The block becomes Shared with the requester added to its sharers.
- R3: A write miss (`req_kind`=1) to an Uncached block returns a data reply with the memory value. The block becomes Exclusive with the requester as its only holder.
- R4: A write miss to a Shared block first sends one invalidate (`out_kind`=1) to each sharer other than the requester. These go out on consecutive cycles in ascending processor order. A data reply to the requester follows, and the block becomes Exclusive, owned by the requester. If the requester is the only sharer, the reply goes out with no invalidates.
- R5: A read miss to an Exclusive block sends a fetch (`out_kind`=2) to the owner. When the owner's write back arrives, its data is written to memory and sent to the requester as a data reply. The block becomes Shared, held by the old owner and the requester.
- R6: A write miss to an Exclusive block sends a fetch-and-invalidate (`out_kind`=3) to the owner. When the owner's write back arrives, its data is written to memory and sent to the requester. The block stays Exclusive, now owned by the requester.
- R7: A write back (`req_kind`=2) from the owner of an Exclusive block writes its data to memory and empties the sharer set. The block becomes Uncached, and an acknowledgement (`out_kind`=4, data 0) goes to the writer.
- R8: While a fetch is outstanding, `req_ready` is low for every request except a write back from the fetched owner to the fetched address. A held request produces no output.
- R9: A write back from a processor that does not own the block, or to a block that is not Exclusive, is acknowledged but leaves the directory entry and the memory data unchanged.
- R10: An Exclusive block always has exactly one presence bit set, and an Uncached block has none. Fetches therefore target a single owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this clock edge when high together with req_valid |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write back |
| req_proc | input | PW | Requesting processor number |
| req_addr | input | AW | Block address |
| req_data | input | DW | Write-back data |
| out_valid | output | 1 | Outgoing message valid for this cycle |
| out_kind | output | 3 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate, 4 write-back acknowledgement |
| out_proc | output | PW | Destination processor |
| out_addr | output | AW | Block address of the message |
| out_data | output | DW | Block data for replies, 0 otherwise |

## Verification
Some properties are checked on every cycle. The directory invariants are one: Exclusive means one holder and Uncached means none, for every block. The others are the ascending order of back-to-back invalidates, the refusal of anything but a write back while a fetch is pending, and a quiet output after reset. The bench scenarios are the only place where the message contents are shown correct. They cover the data each reply carries, which caches get invalidated, the owner a fetch goes to, and the refusal of a stray write back. The bench traces each block through sharing, upgrade, ownership transfer, eviction and stray write backs, and compares the exact message order.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {
      DS_UNCACHED = 2'd0,
      DS_SHARED   = 2'd1,
      DS_EXCL     = 2'd2
   } dir_state_e;

   localparam logic [1:0] RQ_READ  = 2'd0;
   localparam logic [1:0] RQ_WRITE = 2'd1;
   localparam logic [1:0] RQ_WBACK = 2'd2;

   localparam logic [2:0] MS_DATA      = 3'd0;
   localparam logic [2:0] MS_INVAL     = 3'd1;
   localparam logic [2:0] MS_FETCH     = 3'd2;
   localparam logic [2:0] MS_FETCH_INV = 3'd3;
   localparam logic [2:0] MS_WB_ACK    = 3'd4;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_INVAL = 2'd1,
      SQ_WAIT  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/dir_lowbit.sv
// Lowest-set-bit picker: gives ascending processor order.
module dir_lowbit #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/dir_store.sv
// Per-block directory state, presence vector and data storage.
module dir_store
   import dir_pkg::*;
#(
   parameter int NBLK  = 8,
   parameter int NPROC = 4,
   parameter int DW    = 32,
   parameter int AW    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [AW-1:0]         blk_addr,
   output logic [1:0]            rd_state,
   output logic [NPROC-1:0]      rd_sharers,
   output logic [DW-1:0]         rd_data,
   input  logic                  dir_we,
   input  logic [1:0]            wr_state,
   input  logic [NPROC-1:0]      wr_sharers,
   input  logic                  mem_we,
   input  logic [DW-1:0]         mem_wdata,
   output logic [2*NBLK-1:0]     st_flat,
   output logic [NPROC*NBLK-1:0] sh_flat
);
   logic [DW*NBLK-1:0] mem_flat;

   for (genvar g = 0; g < NBLK; g++) begin : g_blk
      logic [1:0]       st_r;
      logic [NPROC-1:0] sh_r;
      logic [DW-1:0]    dat_r;
      logic             hit;

      assign hit = (int'(blk_addr) == g);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_r  <= DS_UNCACHED;
            sh_r  <= '0;
            dat_r <= DW'(g);
         end else begin
            if (dir_we && hit) begin
               st_r <= wr_state;
               sh_r <= wr_sharers;
            end
            if (mem_we && hit) begin
               dat_r <= mem_wdata;
            end
         end
      end

      assign st_flat[g*2 +: 2]         = st_r;
      assign sh_flat[g*NPROC +: NPROC] = sh_r;
      assign mem_flat[g*DW +: DW]      = dat_r;
   end

   assign rd_state   = st_flat[int'(blk_addr)*2 +: 2];
   assign rd_sharers = sh_flat[int'(blk_addr)*NPROC +: NPROC];
   assign rd_data    = mem_flat[int'(blk_addr)*DW +: DW];
endmodule

// File: rtl/dir_seq.sv
// Request sequencer: directory transitions and outgoing messages.
module dir_seq
   import dir_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int DW    = 32,
   parameter int AW    = 3,
   parameter int PW    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [1:0]       req_kind,
   input  logic [PW-1:0]    req_proc,
   input  logic [AW-1:0]    req_addr,
   input  logic [DW-1:0]    req_data,
   output logic [AW-1:0]    blk_addr,
   input  logic [1:0]       rd_state,
   input  logic [NPROC-1:0] rd_sharers,
   input  logic [DW-1:0]    rd_data,
   output logic             dir_we,
   output logic [1:0]       wr_state,
   output logic [NPROC-1:0] wr_sharers,
   output logic             mem_we,
   output logic [DW-1:0]    mem_wdata,
   output logic             out_valid,
   output logic [2:0]       out_kind,
   output logic [PW-1:0]    out_proc,
   output logic [AW-1:0]    out_addr,
   output logic [DW-1:0]    out_data,
   output logic             busy
);
   localparam logic [NPROC-1:0] ONE = NPROC'(1);

   seq_state_e       st_q, st_d;
   logic [PW-1:0]    cur_proc_q, cur_proc_d;
   logic [PW-1:0]    owner_q, owner_d;
   logic [AW-1:0]    cur_addr_q, cur_addr_d;
   logic             cur_rd_q, cur_rd_d;
   logic [NPROC-1:0] pend_q, pend_d;

   logic             ov_d;
   logic [2:0]       ok_d;
   logic [PW-1:0]    op_d;
   logic [AW-1:0]    oa_d;
   logic [DW-1:0]    od_d;

   logic             own_found, pend_found;
   logic [PW-1:0]    own_idx, pend_idx;
   logic [NPROC-1:0] req_bit, cur_bit, owner_bit;
   logic             is_excl, is_shared, wb_match;

   dir_lowbit #(.N(NPROC), .IW(PW)) u_owner_pick (
      .vec(rd_sharers), .found(own_found), .idx(own_idx)
   );
   dir_lowbit #(.N(NPROC), .IW(PW)) u_pend_pick (
      .vec(pend_q), .found(pend_found), .idx(pend_idx)
   );

   assign req_bit   = ONE << req_proc;
   assign cur_bit   = ONE << cur_proc_q;
   assign owner_bit = ONE << owner_q;
   assign is_excl   = (rd_state == DS_EXCL) && own_found;
   assign is_shared = (rd_state == DS_SHARED);
   assign wb_match  = req_valid && (req_kind == RQ_WBACK) &&
                      (req_addr == cur_addr_q) && (req_proc == owner_q);
   assign busy      = (st_q == SQ_WAIT);

   always_comb begin
      st_d       = st_q;
      cur_proc_d = cur_proc_q;
      cur_addr_d = cur_addr_q;
      cur_rd_d   = cur_rd_q;
      owner_d    = owner_q;
      pend_d     = pend_q;
      req_ready  = 1'b0;
      blk_addr   = (st_q == SQ_IDLE) ? req_addr : cur_addr_q;
      dir_we     = 1'b0;
      wr_state   = rd_state;
      wr_sharers = rd_sharers;
      mem_we     = 1'b0;
      mem_wdata  = req_data;
      ov_d       = 1'b0;
      ok_d       = MS_DATA;
      op_d       = req_proc;
      od_d       = '0;

      case (st_q)
         SQ_IDLE: begin
            req_ready = 1'b1;
            if (req_valid) begin
               cur_proc_d = req_proc;
               cur_addr_d = req_addr;
               cur_rd_d   = (req_kind == RQ_READ);
               case (req_kind)
                  RQ_READ: begin
                     ov_d = 1'b1;
                     if (is_excl) begin
                        ok_d    = MS_FETCH;
                        op_d    = own_idx;
                        owner_d = own_idx;
                        st_d    = SQ_WAIT;
                     end else begin
                        ok_d       = MS_DATA;
                        od_d       = rd_data;
                        dir_we     = 1'b1;
                        wr_state   = DS_SHARED;
                        wr_sharers = rd_sharers | req_bit;
                     end
                  end
                  RQ_WRITE: begin
                     if (is_excl) begin
                        ov_d    = 1'b1;
                        ok_d    = MS_FETCH_INV;
                        op_d    = own_idx;
                        owner_d = own_idx;
                        st_d    = SQ_WAIT;
                     end else if (is_shared) begin
                        pend_d = rd_sharers & ~req_bit;
                        st_d   = SQ_INVAL;
                     end else begin
                        ov_d       = 1'b1;
                        ok_d       = MS_DATA;
                        od_d       = rd_data;
                        dir_we     = 1'b1;
                        wr_state   = DS_EXCL;
                        wr_sharers = req_bit;
                     end
                  end
                  RQ_WBACK: begin
                     ov_d = 1'b1;
                     ok_d = MS_WB_ACK;
                     if ((rd_state == DS_EXCL) && ((rd_sharers & req_bit) != '0)) begin
                        dir_we     = 1'b1;
                        wr_state   = DS_UNCACHED;
                        wr_sharers = '0;
                        mem_we     = 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end
         SQ_INVAL: begin
            ov_d = 1'b1;
            if (pend_found) begin
               ok_d   = MS_INVAL;
               op_d   = pend_idx;
               pend_d = pend_q & ~(ONE << pend_idx);
            end else begin
               ok_d       = MS_DATA;
               op_d       = cur_proc_q;
               od_d       = rd_data;
               dir_we     = 1'b1;
               wr_state   = DS_EXCL;
               wr_sharers = cur_bit;
               st_d       = SQ_IDLE;
            end
         end
         SQ_WAIT: begin
            if (wb_match) begin
               req_ready  = 1'b1;
               mem_we     = 1'b1;
               ov_d       = 1'b1;
               ok_d       = MS_DATA;
               op_d       = cur_proc_q;
               od_d       = req_data;
               dir_we     = 1'b1;
               wr_state   = cur_rd_q ? DS_SHARED : DS_EXCL;
               wr_sharers = cur_rd_q ? (owner_bit | cur_bit) : cur_bit;
               st_d       = SQ_IDLE;
            end
         end
         default: st_d = SQ_IDLE;
      endcase
      oa_d = blk_addr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         cur_proc_q <= '0;
         cur_addr_q <= '0;
         cur_rd_q   <= 1'b0;
         owner_q    <= '0;
         pend_q     <= '0;
         out_valid  <= 1'b0;
         out_kind   <= MS_DATA;
         out_proc   <= '0;
         out_addr   <= '0;
         out_data   <= '0;
      end else begin
         st_q       <= st_d;
         cur_proc_q <= cur_proc_d;
         cur_addr_q <= cur_addr_d;
         cur_rd_q   <= cur_rd_d;
         owner_q    <= owner_d;
         pend_q     <= pend_d;
         out_valid  <= ov_d;
         out_kind   <= ok_d;
         out_proc   <= op_d;
         out_addr   <= oa_d;
         out_data   <= od_d;
      end
   end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
   import dir_pkg::*;
#(
   parameter  int NPROC = 4,
   parameter  int NBLK  = 8,
   parameter  int DW    = 32,
   localparam int PW    = $clog2(NPROC),
   localparam int AW    = $clog2(NBLK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_kind,
   input  logic [PW-1:0] req_proc,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   output logic          out_valid,
   output logic [2:0]    out_kind,
   output logic [PW-1:0] out_proc,
   output logic [AW-1:0] out_addr,
   output logic [DW-1:0] out_data
);
   if (NPROC < 2) begin : g_bad_nproc
      $error("dir_home_ctrl: NPROC must be at least 2");
   end
   if (NBLK < 2) begin : g_bad_nblk
      $error("dir_home_ctrl: NBLK must be at least 2");
   end
   if (DW < AW) begin : g_bad_dw
      $error("dir_home_ctrl: DW must hold a block index");
   end

   logic [AW-1:0]         blk_addr;
   logic [1:0]            rd_state, wr_state;
   logic [NPROC-1:0]      rd_sharers, wr_sharers;
   logic [DW-1:0]         rd_data, mem_wdata;
   logic                  dir_we, mem_we, busy;
   logic [2*NBLK-1:0]     st_flat;
   logic [NPROC*NBLK-1:0] sh_flat;

   dir_store #(.NBLK(NBLK), .NPROC(NPROC), .DW(DW), .AW(AW)) u_store (
      .clk(clk), .rst_n(rst_n), .blk_addr(blk_addr),
      .rd_state(rd_state), .rd_sharers(rd_sharers), .rd_data(rd_data),
      .dir_we(dir_we), .wr_state(wr_state), .wr_sharers(wr_sharers),
      .mem_we(mem_we), .mem_wdata(mem_wdata),
      .st_flat(st_flat), .sh_flat(sh_flat)
   );

   dir_seq #(.NPROC(NPROC), .DW(DW), .AW(AW), .PW(PW)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
      .req_proc(req_proc), .req_addr(req_addr), .req_data(req_data),
      .blk_addr(blk_addr), .rd_state(rd_state), .rd_sharers(rd_sharers),
      .rd_data(rd_data), .dir_we(dir_we), .wr_state(wr_state),
      .wr_sharers(wr_sharers), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .out_valid(out_valid), .out_kind(out_kind), .out_proc(out_proc),
      .out_addr(out_addr), .out_data(out_data), .busy(busy)
   );
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk
   import dir_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int NBLK  = 8,
   parameter int PW    = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_ready,
   input logic [1:0]            req_kind,
   input logic                  out_valid,
   input logic [2:0]            out_kind,
   input logic [PW-1:0]         out_proc,
   input logic                  busy,
   input logic [2*NBLK-1:0]     st_flat,
   input logic [NPROC*NBLK-1:0] sh_flat
);
   for (genvar g = 0; g < NBLK; g++) begin : g_inv
      // R10: an Exclusive block has exactly one holder
      p_excl_one_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (st_flat[g*2 +: 2] == DS_EXCL) |-> ($countones(sh_flat[g*NPROC +: NPROC]) == 1));
      // R10: an Uncached block has no holders
      p_uncached_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (st_flat[g*2 +: 2] == DS_UNCACHED) |-> (sh_flat[g*NPROC +: NPROC] == '0));
   end

   // R4: back-to-back invalidates walk upward
   p_inval_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == MS_INVAL && $past(out_valid) && $past(out_kind) == MS_INVAL)
      |-> (out_proc > $past(out_proc)));

   // R8: while a fetch is pending, only write backs get in
   p_hold_in_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid && req_ready) |-> (req_kind == RQ_WBACK));

   // R5: a fetch leaves the controller waiting
   p_fetch_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_kind == MS_FETCH || out_kind == MS_FETCH_INV)) |-> busy);

   // R1: first cycle out of reset is quiet
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !out_valid);
endmodule

bind dir_home_ctrl dir_home_chk #(.NPROC(NPROC), .NBLK(NBLK), .PW(PW)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_kind(req_kind), .out_valid(out_valid), .out_kind(out_kind),
   .out_proc(out_proc), .busy(busy), .st_flat(st_flat), .sh_flat(sh_flat)
);

// File: tb/test_dir_home_ctrl.sv
module test_dir_home_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2;
   localparam logic [2:0] O_DATA = 3'd0, O_INV = 3'd1, O_FETCH = 3'd2,
                          O_FINV = 3'd3, O_ACK = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_kind = '0;
   logic [1:0]  req_proc = '0;
   logic [2:0]  req_addr = '0;
   logic [31:0] req_data = '0;
   logic        out_valid;
   logic [2:0]  out_kind;
   logic [1:0]  out_proc;
   logic [2:0]  out_addr;
   logic [31:0] out_data;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      logic [2:0]  kind;
      logic [1:0]  proc;
      logic [2:0]  addr;
      logic [31:0] data;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dir_home_ctrl #(.NPROC(4), .NBLK(8), .DW(32)) i_dir_home_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_proc(req_proc), .req_addr(req_addr),
      .req_data(req_data), .out_valid(out_valid), .out_kind(out_kind),
      .out_proc(out_proc), .out_addr(out_addr), .out_data(out_data)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic expect_msg(input logic [2:0] k, input int p, input int a,
                             input logic [31:0] d, input string tag);
      exp_t e;
      e.kind = k; e.proc = 2'(p); e.addr = 3'(a); e.data = d; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic send(input logic [1:0] k, input int p, input int a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_proc = 2'(p); req_addr = 3'(a); req_data = d;
      forever begin
         #1;
         if (req_ready) break;
         @(negedge clk);
      end
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // Monitor: pops the scoreboard as messages appear.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R1", "unrequested message",
                  {29'd0, out_kind, out_proc, out_addr, out_data}, 64'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(out_kind == e.kind && out_proc == e.proc &&
                  out_addr == e.addr && out_data == e.data, e.tag,
                  "message {kind,proc,addr,data}",
                  {29'd0, out_kind, out_proc, out_addr, out_data},
                  {29'd0, e.kind, e.proc, e.addr, e.data});
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet and ready after reset
      check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
      check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);

      // R2: three readers share block 3 (reset value 3)
      expect_msg(O_DATA, 0, 3, 32'd3, "R2"); send(K_RD, 0, 3, 0);
      expect_msg(O_DATA, 2, 3, 32'd3, "R2"); send(K_RD, 2, 3, 0);
      expect_msg(O_DATA, 1, 3, 32'd3, "R2"); send(K_RD, 1, 3, 0);
      drain();

      // R4: P2 upgrades; P0 then P1 invalidated, then reply
      expect_msg(O_INV, 0, 3, 32'd0, "R4");
      expect_msg(O_INV, 1, 3, 32'd0, "R4");
      expect_msg(O_DATA, 2, 3, 32'd3, "R4");
      send(K_WR, 2, 3, 0);
      drain();

      // R5: P3 reads an Exclusive block owned by P2
      expect_msg(O_FETCH, 2, 3, 32'd0, "R5");
      send(K_RD, 3, 3, 0);
      drain();
      // R8: another request is held while the fetch is outstanding
      @(negedge clk);
      req_valid = 1'b1; req_kind = K_RD; req_proc = 2'd1; req_addr = 3'd5;
      for (int i = 0; i < 3; i++) begin
         #1;
         check(req_ready == 1'b0, "R8", "req_ready while fetching", 64'(req_ready), 64'd0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      expect_msg(O_DATA, 3, 3, 32'hA5A5, "R5");
      send(K_WB, 2, 3, 32'hA5A5);
      drain();

      // R4: sharers P2,P3 invalidated for P0 write; memory now A5A5
      expect_msg(O_INV, 2, 3, 32'd0, "R4");
      expect_msg(O_INV, 3, 3, 32'd0, "R4");
      expect_msg(O_DATA, 0, 3, 32'hA5A5, "R4");
      send(K_WR, 0, 3, 0);
      drain();

      // R6: P1 write to block owned by P0
      expect_msg(O_FINV, 0, 3, 32'd0, "R6");
      send(K_WR, 1, 3, 0);
      drain();
      expect_msg(O_DATA, 1, 3, 32'h1234, "R6");
      send(K_WB, 0, 3, 32'h1234);
      drain();

      // R9: stray write back from non-owner P2 is acknowledged only
      expect_msg(O_ACK, 2, 3, 32'd0, "R9");
      send(K_WB, 2, 3, 32'hDEAD);
      drain();
      // R9/R10: owner still P1, memory not DEAD
      expect_msg(O_FETCH, 1, 3, 32'd0, "R9");
      send(K_RD, 2, 3, 0);
      drain();
      expect_msg(O_DATA, 2, 3, 32'h5555, "R5");
      send(K_WB, 1, 3, 32'h5555);
      drain();

      // R3 then R7 on block 0
      expect_msg(O_DATA, 3, 0, 32'd0, "R3");
      send(K_WR, 3, 0, 0);
      expect_msg(O_ACK, 3, 0, 32'd0, "R7");
      send(K_WB, 3, 0, 32'hBEEF);
      expect_msg(O_DATA, 1, 0, 32'hBEEF, "R7");
      send(K_RD, 1, 0, 0);
      drain();

      // R9: write back to an Uncached block changes nothing
      expect_msg(O_ACK, 2, 6, 32'd0, "R9");
      send(K_WB, 2, 6, 32'hDEAD);
      expect_msg(O_DATA, 0, 6, 32'd6, "R9");
      send(K_RD, 0, 6, 0);
      drain();

      // R2: untouched block returns its reset value
      expect_msg(O_DATA, 0, 7, 32'd7, "R2");
      send(K_RD, 0, 7, 0);
      drain();

      // R4: sole sharer upgrades without invalidates
      expect_msg(O_DATA, 2, 4, 32'd4, "R2");
      send(K_RD, 2, 4, 0);
      expect_msg(O_DATA, 2, 4, 32'd4, "R4");
      send(K_WR, 2, 4, 0);
      drain();

      // R10: ownership passes 0 -> 1, each fetch to one owner
      expect_msg(O_DATA, 0, 5, 32'd5, "R3");
      send(K_WR, 0, 5, 0);
      expect_msg(O_FINV, 0, 5, 32'd0, "R10");
      send(K_WR, 1, 5, 0);
      drain();
      expect_msg(O_DATA, 1, 5, 32'h42, "R6");
      send(K_WB, 0, 5, 32'h42);
      expect_msg(O_FETCH, 1, 5, 32'd0, "R10");
      send(K_RD, 2, 5, 0);
      drain();
      expect_msg(O_DATA, 2, 5, 32'h43, "R5");
      send(K_WB, 1, 5, 32'h43);
      drain();

      check(exp_q.size() == 0, "R1", "messages still expected",
            64'(exp_q.size()), 64'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule